// File: doc/BRIEF.md
# Four-Bit Framed Pattern Detector

This block watches a serial bit stream one bit per clock and cuts it into fixed groups of four bits that never overlap. The first group starts with the first bit taken after reset. On the fourth bit of each group it raises a single-cycle match flag if the whole group is `0101` or `1001`. Bits are compared in the order they arrive, so the first bit of a group is the leftmost bit of the pattern.

The flag is a Mealy output. It depends on the current frame state and on the bit being presented, so it rises in the same cycle as the fourth bit and not one cycle later. After every fourth bit the detector goes back to its start state, whatever the group held. A group that has already failed is still counted out to its end, which keeps the framing intact. A pattern that spans two groups is never reported.

Top module: `quad_frame_matcher`

## Requirements
- R1: After reset, bits are grouped strictly four at a time: bits 1-4 form the first group, bits 5-8 the second, and so on, for any stream content.
- R2: While the fourth bit of a group is presented, `hit` is 1 in that same cycle when the group, in arrival order (first bit leftmost), equals `0101`.
- R3: While the fourth bit of a group is presented, `hit` is 1 in that same cycle when the group, in arrival order, equals `1001`.
- R4: For each of the other fourteen 4-bit group values, `hit` is 0 while the fourth bit is presented.
- R5: `hit` is 0 while the first, second or third bit of any group is presented.
- R6: A pattern that spans a group boundary (for example `0001` followed by `0100`) produces no `hit`.
- R7: A group that stops being a possible match early is still counted out to four bits, and the group after it is detected normally.
- R8: While `rst` is 1 (synchronous, active high), `hit` is 0. The first bit after `rst` is released is bit 1 of a new group, even if reset arrived part way through a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit, one per clock |
| hit | output | 1 | Match flag, Mealy, valid with the fourth bit of a group |

## Verification
The hardest case to reach from the ports is a stream where a valid pattern sits across a group boundary, or where a reset cuts a group in half. Only a detector whose framing has drifted would report either one. The stimulus builds both on purpose: it sends group pairs that hide `0101` and `1001` across the boundary, it asserts reset after two bits of a group, and it follows a group that fails early with a matching group. All sixteen group values are swept in order, and a long pseudo-random stream is then compared against a frame model kept in the bench.

// File: rtl/quad_frame_matcher.sv
module quad_frame_matcher (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit
);

  typedef enum logic [2:0] {
    ST_START,
    ST_LEAD0,
    ST_LEAD1,
    ST_PAIR_OK,
    ST_TRIO_OK,
    ST_LOST2,
    ST_LOST3
  } fstate_t;

  fstate_t cur, nxt;

  always_comb begin
    nxt = ST_START;
    case (cur)
      ST_START:   nxt = bit_in ? ST_LEAD1 : ST_LEAD0;
      ST_LEAD0:   nxt = bit_in ? ST_PAIR_OK : ST_LOST2;
      ST_LEAD1:   nxt = bit_in ? ST_LOST2 : ST_PAIR_OK;
      ST_PAIR_OK: nxt = bit_in ? ST_LOST3 : ST_TRIO_OK;
      ST_LOST2:   nxt = ST_LOST3;
      ST_TRIO_OK: nxt = ST_START;
      ST_LOST3:   nxt = ST_START;
      default:    nxt = ST_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_START;
    else     cur <= nxt;
  end

  assign hit = !rst && (cur == ST_TRIO_OK) && bit_in;

endmodule

// File: rtl/quad_frame_matcher_chk.sv
module quad_frame_matcher_chk (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic hit
);

  logic [1:0] slot;
  logic [2:0] prior;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot  <= 2'd0;
      prior <= 3'd0;
    end else begin
      slot  <= slot + 2'd1;
      prior <= {prior[1:0], bit_in};
    end
  end

  p_reset_quiet_r8: assert property (@(posedge clk) rst |-> !hit);

  p_early_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (slot != 2'd3) |-> !hit);

  p_match_a_r2: assert property (@(posedge clk) disable iff (rst)
    (slot == 2'd3 && {prior, bit_in} == 4'b0101) |-> hit);

  p_match_b_r3: assert property (@(posedge clk) disable iff (rst)
    (slot == 2'd3 && {prior, bit_in} == 4'b1001) |-> hit);

  p_no_match_r4: assert property (@(posedge clk) disable iff (rst)
    (slot == 2'd3 && {prior, bit_in} != 4'b0101 && {prior, bit_in} != 4'b1001) |-> !hit);

endmodule

bind quad_frame_matcher quad_frame_matcher_chk u_chk (
  .clk(clk),
  .rst(rst),
  .bit_in(bit_in),
  .hit(hit)
);

// File: tb/tb_quad_frame_matcher.sv
module tb_quad_frame_matcher;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  want;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit;

  item_t sb[$];
  int n_checks = 0;
  int n_fail = 0;
  int pos = 0;
  logic [2:0] hist = 3'd0;
  bit done = 1'b0;

  quad_frame_matcher dut (.clk(clk), .rst(rst), .bit_in(bit_in), .hit(hit));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic b, input logic r, input string tag);
    item_t it;
    logic [3:0] grp;
    @(negedge clk);
    rst = r;
    bit_in = b;
    grp = {hist, b};
    if (r) begin
      it.want = 1'b0;
      it.req = (tag != "") ? tag : "R8";
      pos = 0;
      hist = 3'd0;
    end else begin
      it.want = (pos == 3) && (grp == 4'b0101 || grp == 4'b1001);
      if (tag != "") it.req = tag;
      else if (pos != 3) it.req = "R5";
      else if (grp == 4'b0101) it.req = "R2";
      else if (grp == 4'b1001) it.req = "R3";
      else it.req = "R4";
      hist = {hist[1:0], b};
      pos = (pos + 1) % 4;
    end
    sb.push_back(it);
  endtask

  task automatic send_group(input logic [3:0] g, input string tag);
    for (int i = 3; i >= 0; i--) drive(g[i], 1'b0, (i == 0) ? tag : "");
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        n_checks++;
        if (hit !== it.want) begin
          n_fail++;
          $display("FAIL %s: hit=%b expected=%b at %0t", it.req, hit, it.want, $time);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      report();
    end
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    drive(1'b1, 1'b1, "R8");
    drive(1'b1, 1'b1, "R8");
    for (int v = 0; v < 16; v++) send_group(v[3:0], "");
    send_group(4'b0001, "R6");
    send_group(4'b0100, "R6");
    send_group(4'b1110, "R6");
    send_group(4'b0100, "R6");
    send_group(4'b1100, "R7");
    send_group(4'b0101, "R7");
    send_group(4'b1111, "R7");
    send_group(4'b1001, "R7");
    drive(1'b1, 1'b0, "");
    drive(1'b0, 1'b0, "");
    drive(1'b1, 1'b1, "R8");
    send_group(4'b0101, "R8");
    send_group(4'b1001, "R8");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      drive(lfsr[0], 1'b0, (pos == 3) ? "R1" : "");
    end
    repeat (3) @(negedge clk);
    #3;
    done = 1'b1;
    report();
  end
endmodule